// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Master

This block drives a 16-bit-word serial EEPROM over a three-wire link: a select line, a serial clock and a data line out to the device, plus one data line back. The host issues one operation at a time through a request port. The operation is a word read, a word write, a write-enable or write-disable command, or a repeat of width detection. Each operation carries a word address, write data and an address-width select for 6 or 8 bits. The master returns the read word with a one-cycle completion pulse and a timeout flag.

A word write is self-contained. The master first sends an enable command, then the write frame with its data. It polls the device's data line until the device reports ready, and it closes with a disable command. The poll is bounded so that a dead device cannot hang the master.

Out of reset, the master reads word 0 with 8-bit addressing and compares the result with a signature. The outcome picks the address width the host should use.

Top module: `mw_eeprom_ctrl`

## Requirements
- R1: After reset the master reads word 0 using 8-bit addressing, holding `idle` low until that read ends. `det_wide` becomes 1 when the word equals `WIDE_SIG` (default 0x8129) and 0 otherwise. This reset-time detection gives no `rsp_done` pulse.
- R2: A read (op 0) sends a start bit 1, the opcode bits 10 and the address MSB first. The address is 8 bits when `req_wide`=1 and its low 6 bits when `req_wide`=0. The master then clocks in 16 bits MSB first and presents them on `rsp_rdata` when `rsp_done` pulses.
- R3: `mw_mosi` changes only while `mw_sck` is low. Each high phase of `mw_sck` lasts exactly `DIV` clock cycles.
- R4: `mw_sck` is low whenever `mw_cs` is low. Select drops for at least one phase between any two commands.
- R5: A write (op 1) runs four steps in order: an enable command, the write command, a ready poll and a disable command. The enable command is code 100 with address top bits 11. The write command is start bit 1, opcode 01, the address, then 16 data bits MSB first. The disable command is code 100 with address top bits 00. After the operation the device holds the new word and is write-disabled.
- R6: During the poll, `mw_cs` is high and `mw_sck` is low, and `mw_miso` is sampled once per phase. A high sample ends the poll, and the write completes with `rsp_timeout`=0.
- R7: If `POLL_MAX` samples pass without a high level, the poll stops. The disable command is still sent, and the write completes with `rsp_timeout`=1.
- R8: A command request (op 2) sends code 100 with address top bits 11 when `req_enable`=1, and with top bits 00 when `req_enable`=0. It then pulses `rsp_done`.
- R9: A request is taken only on a cycle where `idle`=1 and `req_valid`=1. A `req_valid` pulse while busy sends nothing to the device. A request held high through the completion cycle is taken on the clock edge that ends that cycle.
- R10: `rsp_done` is a single-cycle pulse that coincides with `idle`=1. `rsp_timeout` keeps its value until the next request is taken.
- R11: A detect request (op 3) repeats the R1 read, updates `det_wide` in either direction and pulses `rsp_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 read, 1 write, 2 enable/disable command, 3 detect |
| req_addr | input | 8 | Word address (low 6 bits used when narrow) |
| req_wdata | input | 16 | Write data |
| req_enable | input | 1 | For op 2: 1 enable, 0 disable |
| req_wide | input | 1 | 1 selects 8-bit, 0 selects 6-bit addressing |
| idle | output | 1 | Master can take a request |
| rsp_done | output | 1 | Operation completed (one-cycle pulse) |
| rsp_rdata | output | 16 | Word from the last read or detect |
| rsp_timeout | output | 1 | Last write's ready poll expired |
| det_wide | output | 1 | Detected width is 8 bits |
| mw_cs | output | 1 | Device select |
| mw_sck | output | 1 | Serial clock |
| mw_mosi | output | 1 | Serial data to the device |
| mw_miso | input | 1 | Serial data from the device |

## Verification
Two events can fall in the same cycle: completion of one operation, and the host's next request. The bench provokes this by holding `req_valid` high with new fields through the completion pulse. It judges the result by three things: the first read word is still intact in the pulse cycle, `idle` has dropped one cycle later, and the second operation returns its own word. A second overlap comes from a request pulsed in the middle of a read. That request must leave the device model's command counters unchanged and must produce no extra completion.

// File: rtl/mwe_pkg.sv
// Shared constants, types and frame packing for the serial EEPROM master.
// Assumes 16-bit device words and address widths of 8 or 6 bits.
package mwe_pkg;
    localparam int ADDR_W   = 8;
    localparam int NARROW_W = 6;
    localparam int WORD_W   = 16;
    localparam int FRAME_W  = 3 + ADDR_W + WORD_W;
    localparam int LEN_W    = $clog2(FRAME_W + WORD_W + 1);

    typedef enum logic [1:0] {
        OP_READ   = 2'd0,
        OP_WRITE  = 2'd1,
        OP_EXT    = 2'd2,
        OP_DETECT = 2'd3
    } op_t;

    typedef enum logic [2:0] {
        CODE_EXT   = 3'b100,
        CODE_WRITE = 3'b101,
        CODE_READ  = 3'b110
    } code_t;

    typedef enum logic [1:0] {
        SUB_DIS = 2'b00,
        SUB_EN  = 2'b11
    } sub_t;

    typedef enum logic [2:0] {
        SQ_DETECT, SQ_IDLE, SQ_READ, SQ_WEN, SQ_WRITE, SQ_POLL, SQ_WDIS, SQ_EXT
    } seq_t;

    typedef enum logic [2:0] {
        FE_IDLE, FE_PRE, FE_SEL, FE_LO, FE_HI, FE_POLL, FE_END
    } fe_t;

    // Left-aligned frame: code, address (8 or 6 bits), then data
    function automatic logic [FRAME_W-1:0] pack_cmd(input logic [2:0] code,
                                                    input logic [ADDR_W-1:0] addr,
                                                    input logic [WORD_W-1:0] data,
                                                    input logic wide);
        if (wide)
            return {code, addr, data};
        else
            return {code, addr[NARROW_W-1:0], data, {(ADDR_W-NARROW_W){1'b0}}};
    endfunction

    // Sub-code placed in the two most significant address bits
    function automatic logic [ADDR_W-1:0] ext_addr(input logic [1:0] sub, input logic wide);
        if (wide)
            return {sub, {(ADDR_W-2){1'b0}}};
        else
            return {{(ADDR_W-NARROW_W){1'b0}}, sub, {(NARROW_W-2){1'b0}}};
    endfunction
endpackage

// File: rtl/mwe_phase_timer.sv
// Phase timer: emits a one-cycle tick every DIV clocks; restart re-aligns
// the count so that the first phase after a restart lasts exactly DIV clocks.
// Assumes DIV >= 1.
module mwe_phase_timer #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    // Count clocks within one phase
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/mwe_frame_engine.sv
// Frame engine: runs one select window on the three-wire link. It holds
// select low for a phase, raises it, then either shifts out_len bits out
// (plus 16 bits in when rx_word) or polls mw_miso for ready, then drops
// select for a closing phase. Assumes start only arrives while idle and
// that tx_bits is left-aligned.
module mwe_frame_engine
    import mwe_pkg::*;
#(
    parameter int POLL_MAX = 20000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               start,
    input  logic [FRAME_W-1:0] tx_bits,
    input  logic [LEN_W-1:0]   out_len,
    input  logic               rx_word,
    input  logic               poll,
    input  logic               miso,
    output logic               restart,
    output logic               cs,
    output logic               sck,
    output logic               mosi,
    output logic               done,
    output logic [WORD_W-1:0]  rx,
    output logic               expired
);
    localparam int PW = (POLL_MAX > 1) ? $clog2(POLL_MAX) : 1;
    localparam logic [PW-1:0] PLAST = PW'(POLL_MAX - 1);
    localparam logic [LEN_W-1:0] IN_LEN = LEN_W'(WORD_W);

    fe_t                st;
    logic [FRAME_W-1:0] tx;
    logic [LEN_W-1:0]   left;
    logic [LEN_W-1:0]   nin;
    logic               poll_q;
    logic [PW-1:0]      pcnt;

    // Pin levels follow the phase state
    always_comb begin
        cs   = (st == FE_SEL) || (st == FE_LO) || (st == FE_HI) || (st == FE_POLL);
        sck  = (st == FE_HI);
        mosi = ((st == FE_LO) || (st == FE_HI)) ? tx[FRAME_W-1] : 1'b0;
    end

    assign restart = (st == FE_IDLE) && start;

    // Phase sequencing, shifting, sampling and ready polling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= FE_IDLE;
            tx      <= '0;
            left    <= '0;
            nin     <= '0;
            poll_q  <= 1'b0;
            pcnt    <= '0;
            rx      <= '0;
            expired <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                FE_IDLE: if (start) begin
                    st      <= FE_PRE;
                    tx      <= tx_bits;
                    left    <= out_len + (rx_word ? IN_LEN : '0);
                    nin     <= rx_word ? IN_LEN : '0;
                    poll_q  <= poll;
                    pcnt    <= '0;
                    expired <= 1'b0;
                end
                FE_PRE: if (tick) st <= FE_SEL;
                FE_SEL: if (tick) st <= poll_q ? FE_POLL : FE_LO;
                FE_LO:  if (tick) st <= FE_HI;
                FE_HI: if (tick) begin
                    if (left <= nin)
                        rx <= {rx[WORD_W-2:0], miso};
                    tx   <= tx << 1;
                    left <= left - 1'b1;
                    st   <= (left == LEN_W'(1)) ? FE_END : FE_LO;
                end
                FE_POLL: if (tick) begin
                    if (miso)
                        st <= FE_END;
                    else if (pcnt == PLAST) begin
                        expired <= 1'b1;
                        st      <= FE_END;
                    end else
                        pcnt <= pcnt + 1'b1;
                end
                FE_END: if (tick) begin
                    st   <= FE_IDLE;
                    done <= 1'b1;
                end
                default: st <= FE_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mw_eeprom_ctrl.sv
// Serial EEPROM master top: accepts one request while idle and breaks it
// into frames (read, enable/write/poll/disable, single command, or width
// detection), each run by the frame engine. Assumes the host feeds
// det_wide back as req_wide for the device in use.
module mw_eeprom_ctrl
    import mwe_pkg::*;
#(
    parameter int          DIV      = 8,
    parameter int          POLL_MAX = 20000,
    parameter logic [15:0] WIDE_SIG = 16'h8129
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic              req_enable,
    input  logic              req_wide,
    output logic              idle,
    output logic              rsp_done,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic              rsp_timeout,
    output logic              det_wide,
    output logic              mw_cs,
    output logic              mw_sck,
    output logic              mw_mosi,
    input  logic              mw_miso
);
    localparam logic [LEN_W-1:0] LEN_CMD_W = LEN_W'(3 + ADDR_W);
    localparam logic [LEN_W-1:0] LEN_CMD_N = LEN_W'(3 + NARROW_W);
    localparam logic [LEN_W-1:0] LEN_DAT   = LEN_W'(WORD_W);

    seq_t               sq;
    logic               pending;
    logic               user_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [WORD_W-1:0]  wdata_q;
    logic               en_q;
    logic               wide_q;
    logic               to_q;

    logic               f_start, f_restart, f_tick, f_done, f_expired;
    logic [FRAME_W-1:0] f_tx;
    logic [LEN_W-1:0]   f_len;
    logic [LEN_W-1:0]   cmd_len;
    logic               f_rxw, f_poll;
    logic [WORD_W-1:0]  f_rx;

    assign idle    = (sq == SQ_IDLE);
    assign f_start = pending && (sq != SQ_IDLE);
    assign cmd_len = wide_q ? LEN_CMD_W : LEN_CMD_N;

    // Frame contents for the current sequencer step
    always_comb begin
        f_tx   = '0;
        f_len  = cmd_len;
        f_rxw  = 1'b0;
        f_poll = 1'b0;
        case (sq)
            SQ_DETECT: begin
                f_tx  = pack_cmd(CODE_READ, '0, '0, 1'b1);
                f_len = LEN_CMD_W;
                f_rxw = 1'b1;
            end
            SQ_READ: begin
                f_tx  = pack_cmd(CODE_READ, addr_q, '0, wide_q);
                f_rxw = 1'b1;
            end
            SQ_WEN:   f_tx = pack_cmd(CODE_EXT, ext_addr(SUB_EN, wide_q), '0, wide_q);
            SQ_WRITE: begin
                f_tx  = pack_cmd(CODE_WRITE, addr_q, wdata_q, wide_q);
                f_len = cmd_len + LEN_DAT;
            end
            SQ_POLL: begin
                f_len  = '0;
                f_poll = 1'b1;
            end
            SQ_WDIS:  f_tx = pack_cmd(CODE_EXT, ext_addr(SUB_DIS, wide_q), '0, wide_q);
            SQ_EXT:   f_tx = pack_cmd(CODE_EXT, ext_addr(en_q ? SUB_EN : SUB_DIS, wide_q), '0, wide_q);
            default: ;
        endcase
    end

    // Request acceptance and step-by-step sequencing of frames
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq          <= SQ_DETECT;
            pending     <= 1'b1;
            user_q      <= 1'b0;
            addr_q      <= '0;
            wdata_q     <= '0;
            en_q        <= 1'b0;
            wide_q      <= 1'b1;
            to_q        <= 1'b0;
            rsp_done    <= 1'b0;
            rsp_rdata   <= '0;
            rsp_timeout <= 1'b0;
            det_wide    <= 1'b0;
        end else begin
            rsp_done <= 1'b0;
            if (f_start)
                pending <= 1'b0;
            if (sq == SQ_IDLE) begin
                if (req_valid) begin
                    addr_q      <= req_addr;
                    wdata_q     <= req_wdata;
                    en_q        <= req_enable;
                    wide_q      <= req_wide;
                    user_q      <= 1'b1;
                    rsp_timeout <= 1'b0;
                    pending     <= 1'b1;
                    case (req_op)
                        OP_READ:  sq <= SQ_READ;
                        OP_WRITE: sq <= SQ_WEN;
                        OP_EXT:   sq <= SQ_EXT;
                        default:  sq <= SQ_DETECT;
                    endcase
                end
            end else if (f_done) begin
                pending <= 1'b1;
                case (sq)
                    SQ_DETECT: begin
                        det_wide  <= (f_rx == WIDE_SIG);
                        rsp_rdata <= f_rx;
                        rsp_done  <= user_q;
                        pending   <= 1'b0;
                        sq        <= SQ_IDLE;
                    end
                    SQ_READ: begin
                        rsp_rdata <= f_rx;
                        rsp_done  <= 1'b1;
                        pending   <= 1'b0;
                        sq        <= SQ_IDLE;
                    end
                    SQ_WEN:   sq <= SQ_WRITE;
                    SQ_WRITE: sq <= SQ_POLL;
                    SQ_POLL: begin
                        to_q <= f_expired;
                        sq   <= SQ_WDIS;
                    end
                    SQ_WDIS: begin
                        rsp_timeout <= to_q;
                        rsp_done    <= 1'b1;
                        pending     <= 1'b0;
                        sq          <= SQ_IDLE;
                    end
                    default: begin
                        rsp_done <= 1'b1;
                        pending  <= 1'b0;
                        sq       <= SQ_IDLE;
                    end
                endcase
            end
        end
    end

    mwe_phase_timer #(.DIV(DIV)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (f_restart),
        .tick    (f_tick)
    );

    mwe_frame_engine #(.POLL_MAX(POLL_MAX)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (f_tick),
        .start   (f_start),
        .tx_bits (f_tx),
        .out_len (f_len),
        .rx_word (f_rxw),
        .poll    (f_poll),
        .miso    (mw_miso),
        .restart (f_restart),
        .cs      (mw_cs),
        .sck     (mw_sck),
        .mosi    (mw_mosi),
        .done    (f_done),
        .rx      (f_rx),
        .expired (f_expired)
    );
endmodule

// File: rtl/mw_eeprom_ctrl_chk.sv
// Checker for the serial EEPROM master: link timing, select gating and
// request/response handshake rules. Bound into every instance of the top.
module mw_eeprom_ctrl_chk #(
    parameter int DIV = 8
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic idle,
    input logic rsp_done,
    input logic mw_cs,
    input logic mw_sck,
    input logic mw_mosi
);
    int hi_len;

    // Length of the current serial clock high phase
    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_len <= 0;
        else if (mw_sck)
            hi_len <= hi_len + 1;
        else
            hi_len <= 0;
    end

    // R3
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mw_sck && $past(mw_sck)) |-> $stable(mw_mosi));

    // R3
    sck_high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mw_sck) |-> (hi_len == DIV));

    // R4
    sck_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mw_cs |-> !mw_sck);

    // R4
    cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mw_cs) |=> !mw_cs);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> idle);

    // R9
    accept_only_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(idle) |-> $past(req_valid));
endmodule

bind mw_eeprom_ctrl mw_eeprom_ctrl_chk #(.DIV(DIV)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .idle      (idle),
    .rsp_done  (rsp_done),
    .mw_cs     (mw_cs),
    .mw_sck    (mw_sck),
    .mw_mosi   (mw_mosi)
);

// File: tb/mw_eeprom_ctrl_test.sv
// Directed bench with a behavioural three-wire EEPROM model.
module mw_eeprom_ctrl_test;
    localparam int DIV = 4;
    localparam int PMAX = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [7:0]  req_addr = 8'd0;
    logic [15:0] req_wdata = 16'd0;
    logic        req_enable = 1'b0;
    logic        req_wide = 1'b1;
    logic        idle, rsp_done, rsp_timeout, det_wide;
    logic [15:0] rsp_rdata;
    logic        mw_cs, mw_sck, mw_mosi;
    logic        mw_miso = 1'b0;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    mw_eeprom_ctrl #(.DIV(DIV), .POLL_MAX(PMAX)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_enable(req_enable),
        .req_wide(req_wide), .idle(idle), .rsp_done(rsp_done),
        .rsp_rdata(rsp_rdata), .rsp_timeout(rsp_timeout), .det_wide(det_wide),
        .mw_cs(mw_cs), .mw_sck(mw_sck), .mw_mosi(mw_mosi), .mw_miso(mw_miso)
    );

    // ---------------- behavioural device model ----------------
    int          model_aw = 8;
    int          busy_time = 30;
    logic [15:0] mem [256];
    logic        ps_sck = 1'b0, ps_cs = 1'b0;
    int          mst = 3;
    logic        started = 1'b0;
    int          nbits = 0;
    logic [15:0] sr = '0;
    logic [15:0] nsr_v;
    int          addr_v;
    int          sub_v;
    logic [7:0]  m_addr = '0;
    logic [15:0] dout = '0;
    logic [15:0] wbuf = '0;
    int          wcnt = 0;
    logic        wr_armed = 1'b0;
    logic        wen = 1'b0;
    int          busy_left = 0;
    int          ext_cnt = 0, wr_cnt = 0, rd_cnt = 0, last_sub = -1;

    always @(posedge clk) begin
        ps_sck <= mw_sck;
        ps_cs  <= mw_cs;
        if (busy_left > 0) busy_left <= busy_left - 1;
        if (mw_cs && !ps_cs) begin
            mst <= 0; started <= 1'b0; nbits <= 0; sr <= '0; wr_armed <= 1'b0;
        end else if (!mw_cs && ps_cs) begin
            if (wr_armed && wen) begin
                mem[m_addr] <= wbuf;
                wr_cnt      <= wr_cnt + 1;
                busy_left   <= busy_time;
            end
            wr_armed <= 1'b0;
            mst      <= 3;
        end else if (mw_cs && mw_sck && !ps_sck) begin
            if (mst == 0) begin
                if (!started) started <= mw_mosi;
                else begin
                    nsr_v = {sr[14:0], mw_mosi};
                    sr    <= nsr_v;
                    nbits <= nbits + 1;
                    if (nbits + 1 == 2 + model_aw) begin
                        addr_v = int'(nsr_v) & ((1 << model_aw) - 1);
                        m_addr <= 8'(addr_v);
                        case (nsr_v[model_aw +: 2])
                            2'b10: begin mst <= 1; dout <= mem[addr_v]; rd_cnt <= rd_cnt + 1; end
                            2'b01: begin mst <= 2; wcnt <= 0; end
                            2'b00: begin
                                sub_v = (addr_v >> (model_aw - 2)) & 3;
                                if (sub_v == 3) wen <= 1'b1;
                                if (sub_v == 0) wen <= 1'b0;
                                last_sub <= sub_v;
                                ext_cnt  <= ext_cnt + 1;
                                mst      <= 3;
                            end
                            default: mst <= 3;
                        endcase
                    end
                end
            end else if (mst == 2) begin
                wbuf <= {wbuf[14:0], mw_mosi};
                wcnt <= wcnt + 1;
                if (wcnt == 15) begin wr_armed <= 1'b1; mst <= 3; end
            end
        end else if (mw_cs && !mw_sck && ps_sck && mst == 1) begin
            mw_miso <= dout[15];
            dout    <= dout << 1;
        end
        if (mw_cs && mst == 0 && !started)
            mw_miso <= (busy_left == 0);
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] op, input logic [7:0] a, input logic [15:0] d,
                        input logic en, input logic wide);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
        req_enable = en; req_wide = wide;
        while (!idle) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(output logic [15:0] rd, output logic to);
        int n = 0;
        @(negedge clk);
        while (!rsp_done && n < 20000) begin @(negedge clk); n++; end
        rd = rsp_rdata; to = rsp_timeout;
        chk(rsp_done, "R10 completion pulse seen", int'(rsp_done), 1);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        bit saw_done = 0;
        int n = 0;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(!mw_cs && !idle && !rsp_done, "R1 reset state", {mw_cs, idle, rsp_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!idle, "R1 busy detecting", int'(idle), 0);
        while (!idle && n < 5000) begin
            @(negedge clk); n++;
            if (rsp_done) saw_done = 1;
        end
        chk(det_wide == 1'b1, "R1 signature gives wide", int'(det_wide), 1);
        chk(rd_cnt == 1, "R1 one read of word 0", rd_cnt, 1);
        chk(!saw_done, "R1 no done pulse at reset detect", int'(saw_done), 0);
    endtask

    task automatic t_read_wide();
        logic [15:0] rd; logic to;
        send(2'd0, 8'h05, '0, 1'b0, 1'b1);
        wait_done(rd, to);
        chk(rd == mem[5], "R2 wide read addr 05", rd, mem[5]);
        send(2'd0, 8'hFF, '0, 1'b0, 1'b1);
        wait_done(rd, to);
        chk(rd == mem[255], "R2 wide read top addr", rd, mem[255]);
    endtask

    task automatic t_write_ok();
        logic [15:0] rd; logic to;
        int e0 = ext_cnt, w0 = wr_cnt;
        busy_time = 30;
        send(2'd1, 8'h10, 16'hA5C3, 1'b0, 1'b1);
        wait_done(rd, to);
        chk(to == 1'b0, "R6 ready ends poll, no timeout", int'(to), 0);
        chk(mem[16] == 16'hA5C3, "R5 word stored", mem[16], 16'hA5C3);
        chk(wr_cnt == w0 + 1 && ext_cnt == e0 + 2, "R5 enable+write+disable", ext_cnt - e0, 2);
        chk(wen == 1'b0 && last_sub == 0, "R5 ends write-disabled", int'(wen), 0);
        send(2'd0, 8'h10, '0, 1'b0, 1'b1);
        wait_done(rd, to);
        chk(rd == 16'hA5C3, "R5 readback", rd, 16'hA5C3);
    endtask

    task automatic t_write_timeout();
        logic [15:0] rd; logic to;
        int e0 = ext_cnt;
        busy_time = 2000;
        send(2'd1, 8'h20, 16'h1357, 1'b0, 1'b1);
        wait_done(rd, to);
        chk(to == 1'b1, "R7 poll expiry flags timeout", int'(to), 1);
        chk(ext_cnt == e0 + 2 && wen == 1'b0, "R7 disable still sent", ext_cnt - e0, 2);
        repeat (20) @(negedge clk);
        chk(rsp_timeout == 1'b1, "R10 timeout held while idle", int'(rsp_timeout), 1);
        repeat (2000) @(negedge clk);
        busy_time = 30;
    endtask

    task automatic t_ext();
        logic [15:0] rd; logic to;
        send(2'd2, 8'h00, '0, 1'b1, 1'b1);
        wait_done(rd, to);
        chk(wen == 1'b1 && last_sub == 3, "R8 enable command", last_sub, 3);
        chk(to == 1'b0, "R10 timeout cleared on new request", int'(to), 0);
        send(2'd2, 8'h00, '0, 1'b0, 1'b1);
        wait_done(rd, to);
        chk(wen == 1'b0 && last_sub == 0, "R8 disable command", last_sub, 0);
    endtask

    task automatic t_busy_ignore();
        logic [15:0] rd; logic to;
        int e0, w0, r0;
        bit extra = 0;
        send(2'd0, 8'h07, '0, 1'b0, 1'b1);
        e0 = ext_cnt; w0 = wr_cnt; r0 = rd_cnt;
        repeat (20) @(negedge clk);
        req_valid = 1'b1; req_op = 2'd1; req_addr = 8'h07; req_wdata = 16'hDEAD;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done(rd, to);
        chk(rd == mem[7], "R9 read unaffected by busy request", rd, mem[7]);
        repeat (300) begin
            @(negedge clk);
            if (rsp_done || !idle) extra = 1;
        end
        chk(!extra, "R9 busy request not taken", int'(extra), 0);
        chk(ext_cnt == e0 && wr_cnt == w0 && rd_cnt == r0 + 1, "R9 no extra device command",
            ext_cnt + wr_cnt, e0 + w0);
    endtask

    task automatic t_back_to_back();
        int n = 0;
        logic [15:0] rd; logic to;
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd0; req_addr = 8'h33; req_wide = 1'b1;
        while (!idle) @(negedge clk);
        @(negedge clk);
        req_addr = 8'h44;
        while (!rsp_done && n < 20000) begin @(negedge clk); n++; end
        chk(rsp_done && idle, "R10 done with idle", {rsp_done, idle}, 3);
        chk(rsp_rdata == mem[8'h33], "R9 first word at overlap", rsp_rdata, mem[8'h33]);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!idle, "R9 taken in done cycle", int'(idle), 0);
        wait_done(rd, to);
        chk(rd == mem[8'h44], "R9 second word", rd, mem[8'h44]);
    endtask

    task automatic t_narrow();
        logic [15:0] rd; logic to;
        model_aw = 6;
        mem[0] = 16'h1234;
        send(2'd3, 8'h00, '0, 1'b0, 1'b1);
        wait_done(rd, to);
        chk(det_wide == 1'b0, "R11 redetect narrow", int'(det_wide), 0);
        send(2'd0, 8'h3F, '0, 1'b0, 1'b0);
        wait_done(rd, to);
        chk(rd == mem[63], "R2 narrow read addr 3F", rd, mem[63]);
        send(2'd1, 8'h21, 16'h0F0F, 1'b0, 1'b0);
        wait_done(rd, to);
        chk(mem[33] == 16'h0F0F && !to, "R5 narrow write", mem[33], 16'h0F0F);
        chk(wen == 1'b0, "R5 narrow ends disabled", int'(wen), 0);
        model_aw = 8;
        mem[0] = 16'h8129;
        send(2'd3, 8'h00, '0, 1'b0, 1'b1);
        wait_done(rd, to);
        chk(det_wide == 1'b1 && rd == 16'h8129, "R11 redetect wide", rd, 16'h8129);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'(i * 257) ^ 16'h5A3C;
        mem[0] = 16'h8129;
        t_reset();
        t_read_wide();
        t_write_ok();
        t_write_timeout();
        t_ext();
        t_busy_ignore();
        t_back_to_back();
        t_narrow();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule